// File: doc/BRIEF.md
# OTP Fuse Program and Sense Sequencer

This block sits between a simple register bus and a one-time-programmable fuse array and turns register writes into correctly timed fuse accesses. Software loads a timing word (counts in clock cycles), writes a control word carrying a 16-bit unlock key and a 7-bit word address, then either writes the data register to burn a 32-bit value or sets a start bit in the read-control register to sense a word. While a cycle runs a busy bit is visible in the control register, and illegal accesses latch a sticky error bit that software clears through a separate clear register.

Every strobe is framed by a relax phase of relax+1 cycles before and after it. The strobe counts in the timing word already include those two relax phases, so the sequencer derives the active strobe width from them. A behavioural fuse array, in which programming can only set bits, is built in so the whole path can be exercised from the bus.

Top module: `otp_seq_ctrl`

## Requirements
- R1: After reset the control register (offset 0) and the timing register (offset 2) read as zero, and neither fuse strobe is asserted. Register offsets: 0 control, 1 error clear, 2 timing, 3 program data, 4 read control, 5 read data; a read issued in one cycle returns its value on bus_rdata in the next cycle.
- R2: A write to the data register starts a program cycle only if control bits 31:16 hold 0x3E77 and no cycle is running; otherwise control bit 9 (error) is set, no strobe is driven and the fuse array is left unchanged.
- R3: Control bit 8 (busy) reads 1 for the whole duration of a program or sense cycle and 0 otherwise; writes to the control register while busy is set are ignored.
- R4: The error bit is sticky: it is cleared only by writing the error clear register with bit 9 set; a write to that register with bit 9 clear has no effect.
- R5: Control bits 6:0 hold the fuse word address (bank times 8 plus word) and drive fuse_addr unchanged for the whole strobe; fuse_wdata carries the written value during a program strobe.
- R6: Writing read control with bit 0 set starts a sense cycle; when busy drops, the read-data register holds the sensed word. Writing it with bit 0 clear starts nothing.
- R7: Programming only sets bits: the stored word becomes the old word OR the written value.
- R8: The timing register holds the program-strobe count in bits 11:0, the relax count in bits 15:12 and the read-strobe count in bits 21:16, other bits reading 0. Each cycle is relax+1 idle-strobe cycles, a strobe of max(1, count+1-2*(relax+1)) cycles, then relax+1 idle-strobe cycles.
- R9: The unlock key field returns to zero at the end of every program cycle, so a second data write without a fresh key write is rejected as in R2.
- R10: A read-control write with bit 0 set while busy is set starts nothing and sets the error bit; the running cycle completes unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| fuse_addr | output | 7 | Fuse word address to the array |
| fuse_wdata | output | 32 | Value being burned |
| fuse_prog_strobe | output | 1 | Program strobe to the array |
| fuse_sense_strobe | output | 1 | Sense strobe to the array |

## Verification
The hardest situations to reach are the accesses that land in the middle of a running cycle: a second data write, a sense request and a control rewrite while busy is set, each of which must be refused without disturbing the burn already under way. The bench issues these writes in the cycles right after a program start, while the pre-strobe relax phase is still running, then checks that the error bit is set, the address is unchanged and the sensed word carries only the first value. Strobe width and relax framing are measured at the fuse pins across random timing words, including counts small enough to force the one-cycle minimum strobe.

// File: rtl/otp_pkg.sv
package otp_pkg;
  localparam int REG_AW = 3;
  localparam int BUS_W  = 32;

  typedef enum logic [REG_AW-1:0] {
    RA_CTRL   = 3'd0,
    RA_CLR    = 3'd1,
    RA_TIMING = 3'd2,
    RA_DATA   = 3'd3,
    RA_RDCTL  = 3'd4,
    RA_RDDATA = 3'd5
  } reg_addr_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_PRE,
    PH_STB,
    PH_POST
  } phase_e;

  localparam int BUSY_BIT  = 8;
  localparam int ERR_BIT   = 9;
  localparam int KEY_LSB   = 16;
  localparam int T_RLX_LSB = 12;
  localparam int T_RD_LSB  = 16;
endpackage

// File: rtl/otp_regfile.sv
module otp_regfile
  import otp_pkg::*;
#(
  parameter int          ADDR_W = 7,
  parameter int          KEY_W  = 16,
  parameter logic [15:0] KEY    = 16'h3E77,
  parameter int          PCNT_W = 12,
  parameter int          RLX_W  = 4,
  parameter int          RCNT_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              seq_busy,
  input  logic              seq_done,
  input  logic              seq_is_prog,
  input  logic [BUS_W-1:0]  sense_word,
  output logic              start,
  output logic              start_prog,
  output logic [ADDR_W-1:0] cfg_addr,
  output logic [RLX_W-1:0]  cfg_relax,
  output logic [PCNT_W-1:0] cfg_cnt
);
  logic [KEY_W-1:0]  key_q;
  logic [ADDR_W-1:0] addr_q;
  logic              err_q;
  logic [PCNT_W-1:0] tprog_q;
  logic [RLX_W-1:0]  trelax_q;
  logic [RCNT_W-1:0] tread_q;

  logic wr_ctrl, wr_clr, wr_tim, wr_data, wr_rdctl;
  logic go_prog, go_sense, bad_prog, bad_sense;

  assign wr_ctrl  = bus_wr && (bus_addr == RA_CTRL);
  assign wr_clr   = bus_wr && (bus_addr == RA_CLR);
  assign wr_tim   = bus_wr && (bus_addr == RA_TIMING);
  assign wr_data  = bus_wr && (bus_addr == RA_DATA);
  assign wr_rdctl = bus_wr && (bus_addr == RA_RDCTL) && bus_wdata[0];

  assign go_prog   = wr_data && !seq_busy && (key_q == KEY[KEY_W-1:0]);
  assign bad_prog  = wr_data && !go_prog;
  assign go_sense  = wr_rdctl && !seq_busy;
  assign bad_sense = wr_rdctl && seq_busy;

  assign start      = go_prog || go_sense;
  assign start_prog = go_prog;
  assign cfg_addr   = addr_q;
  assign cfg_relax  = trelax_q;
  assign cfg_cnt    = go_prog ? tprog_q : PCNT_W'(tread_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      key_q    <= '0;
      addr_q   <= '0;
      err_q    <= 1'b0;
      tprog_q  <= '0;
      trelax_q <= '0;
      tread_q  <= '0;
    end else begin
      if (wr_ctrl && !seq_busy) begin
        key_q  <= bus_wdata[KEY_LSB +: KEY_W];
        addr_q <= bus_wdata[ADDR_W-1:0];
      end else if (seq_done && seq_is_prog) begin
        key_q <= '0;
      end
      if (bad_prog || bad_sense)
        err_q <= 1'b1;
      else if (wr_clr && bus_wdata[ERR_BIT])
        err_q <= 1'b0;
      if (wr_tim) begin
        tprog_q  <= bus_wdata[PCNT_W-1:0];
        trelax_q <= bus_wdata[T_RLX_LSB +: RLX_W];
        tread_q  <= bus_wdata[T_RD_LSB +: RCNT_W];
      end
    end
  end

  logic [BUS_W-1:0] ctrl_view, tim_view;
  always_comb begin
    ctrl_view = '0;
    ctrl_view[KEY_LSB +: KEY_W] = key_q;
    ctrl_view[ERR_BIT]          = err_q;
    ctrl_view[BUSY_BIT]         = seq_busy;
    ctrl_view[ADDR_W-1:0]       = addr_q;
    tim_view = '0;
    tim_view[PCNT_W-1:0]          = tprog_q;
    tim_view[T_RLX_LSB +: RLX_W]  = trelax_q;
    tim_view[T_RD_LSB +: RCNT_W]  = tread_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        RA_CTRL:   bus_rdata <= ctrl_view;
        RA_TIMING: bus_rdata <= tim_view;
        RA_RDDATA: bus_rdata <= sense_word;
        default:   bus_rdata <= '0;
      endcase
    end
  end

  // R2
  bad_key_err_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_data && (key_q != KEY[KEY_W-1:0])) |=> err_q);
  // R10
  busy_sense_err_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_rdctl && seq_busy) |=> err_q);
  // R9
  key_cleared_chk: assert property (@(posedge clk) disable iff (rst)
    (seq_done && seq_is_prog) |=> (key_q == '0));
  // R4
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (err_q && !(wr_clr && bus_wdata[ERR_BIT])) |=> err_q);
endmodule

// File: rtl/otp_phase_seq.sv
module otp_phase_seq
  import otp_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32,
  parameter int PCNT_W = 12,
  parameter int RLX_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              start_prog,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic [RLX_W-1:0]  cfg_relax,
  input  logic [PCNT_W-1:0] cfg_cnt,
  input  logic [DATA_W-1:0] fuse_rdata,
  output logic              busy,
  output logic              done,
  output logic              is_prog,
  output logic [ADDR_W-1:0] fuse_addr,
  output logic [DATA_W-1:0] fuse_wdata,
  output logic              prog_strobe,
  output logic              sense_strobe,
  output logic [DATA_W-1:0] sense_word
);
  localparam int CW = PCNT_W + 1;

  phase_e          st;
  logic [CW-1:0]   cnt;
  logic [CW-1:0]   width_q;
  logic [RLX_W-1:0] relax_q;
  logic [CW-1:0]   tot, frame, width_c;

  // strobe width = count + 1 - two relax phases, never below one cycle
  always_comb begin
    tot     = CW'(cfg_cnt) + CW'(1);
    frame   = (CW'(cfg_relax) + CW'(1)) << 1;
    width_c = (tot > frame) ? (tot - frame) : CW'(1);
  end

  assign busy         = (st != PH_IDLE);
  assign done         = (st == PH_POST) && (cnt == '0);
  assign prog_strobe  = (st == PH_STB) && is_prog;
  assign sense_strobe = (st == PH_STB) && !is_prog;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= PH_IDLE;
      cnt        <= '0;
      width_q    <= '0;
      relax_q    <= '0;
      is_prog    <= 1'b0;
      fuse_addr  <= '0;
      fuse_wdata <= '0;
      sense_word <= '0;
    end else begin
      case (st)
        PH_IDLE: if (start) begin
          st         <= PH_PRE;
          cnt        <= CW'(cfg_relax);
          relax_q    <= cfg_relax;
          width_q    <= width_c;
          is_prog    <= start_prog;
          fuse_addr  <= cfg_addr;
          fuse_wdata <= start_prog ? cfg_wdata : '0;
        end
        PH_PRE: if (cnt == '0) begin
          st  <= PH_STB;
          cnt <= width_q - CW'(1);
        end else begin
          cnt <= cnt - CW'(1);
        end
        PH_STB: if (cnt == '0) begin
          st  <= PH_POST;
          cnt <= CW'(relax_q);
        end else begin
          cnt <= cnt - CW'(1);
        end
        default: if (cnt == '0) begin
          st <= PH_IDLE;
          if (!is_prog) sense_word <= fuse_rdata;
        end else begin
          cnt <= cnt - CW'(1);
        end
      endcase
    end
  end

  // R8
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({prog_strobe, sense_strobe}));
  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (prog_strobe || sense_strobe) |=> $stable(fuse_addr) && $stable(fuse_wdata));
  // R3
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
  // R8
  pre_relax_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !prog_strobe && !sense_strobe);
endmodule

// File: rtl/otp_fuse_model.sv
module otp_fuse_model #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] fuse_addr,
  input  logic [DATA_W-1:0] fuse_wdata,
  input  logic              prog_strobe,
  input  logic              sense_strobe,
  output logic [DATA_W-1:0] fuse_rdata
);
  localparam int WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [WORDS];
  logic              prog_d;
  logic              burn;

  initial begin
    for (int i = 0; i < WORDS; i++) mem[i] = '0;
  end

  assign burn = prog_d && !prog_strobe;

  always_ff @(posedge clk) begin
    if (rst) begin
      prog_d     <= 1'b0;
      fuse_rdata <= '0;
    end else begin
      prog_d <= prog_strobe;
      if (prog_strobe || sense_strobe)
        fuse_rdata <= mem[fuse_addr];
    end
  end

  // burn at the strobe's trailing edge: only bits can be added
  always_ff @(posedge clk) begin
    if (burn)
      mem[fuse_addr] <= fuse_rdata | fuse_wdata;
  end

  // R7
  burn_grows_chk: assert property (@(posedge clk) disable iff (rst)
    burn |=> ((mem[$past(fuse_addr)] & $past(fuse_rdata)) == $past(fuse_rdata)));
endmodule

// File: rtl/otp_seq_ctrl.sv
module otp_seq_ctrl
  import otp_pkg::*;
#(
  parameter int          ADDR_W = 7,
  parameter int          PCNT_W = 12,
  parameter int          RLX_W  = 4,
  parameter int          RCNT_W = 6,
  parameter logic [15:0] KEY    = 16'h3E77
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic [ADDR_W-1:0] fuse_addr,
  output logic [BUS_W-1:0]  fuse_wdata,
  output logic              fuse_prog_strobe,
  output logic              fuse_sense_strobe
);
  logic              start, start_prog, busy, done, is_prog;
  logic [ADDR_W-1:0] cfg_addr;
  logic [RLX_W-1:0]  cfg_relax;
  logic [PCNT_W-1:0] cfg_cnt;
  logic [BUS_W-1:0]  sense_word, fuse_rdata;

  otp_regfile #(
    .ADDR_W(ADDR_W), .KEY_W(16), .KEY(KEY),
    .PCNT_W(PCNT_W), .RLX_W(RLX_W), .RCNT_W(RCNT_W)
  ) regs_i (
    .clk(clk), .rst(rst),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .seq_busy(busy), .seq_done(done), .seq_is_prog(is_prog),
    .sense_word(sense_word),
    .start(start), .start_prog(start_prog),
    .cfg_addr(cfg_addr), .cfg_relax(cfg_relax), .cfg_cnt(cfg_cnt)
  );

  otp_phase_seq #(
    .ADDR_W(ADDR_W), .DATA_W(BUS_W), .PCNT_W(PCNT_W), .RLX_W(RLX_W)
  ) seq_i (
    .clk(clk), .rst(rst),
    .start(start), .start_prog(start_prog),
    .cfg_addr(cfg_addr), .cfg_wdata(bus_wdata),
    .cfg_relax(cfg_relax), .cfg_cnt(cfg_cnt),
    .fuse_rdata(fuse_rdata),
    .busy(busy), .done(done), .is_prog(is_prog),
    .fuse_addr(fuse_addr), .fuse_wdata(fuse_wdata),
    .prog_strobe(fuse_prog_strobe), .sense_strobe(fuse_sense_strobe),
    .sense_word(sense_word)
  );

  otp_fuse_model #(.ADDR_W(ADDR_W), .DATA_W(BUS_W)) array_i (
    .clk(clk), .rst(rst),
    .fuse_addr(fuse_addr), .fuse_wdata(fuse_wdata),
    .prog_strobe(fuse_prog_strobe), .sense_strobe(fuse_sense_strobe),
    .fuse_rdata(fuse_rdata)
  );
endmodule

// File: tb/otp_seq_ctrl_tb.sv
module otp_seq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] KEY = 16'h3E77;
  localparam logic [2:0] A_CTRL = 3'd0, A_CLR = 3'd1, A_TIM = 3'd2,
                         A_DATA = 3'd3, A_RDCTL = 3'd4, A_RDDATA = 3'd5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [6:0] fuse_addr;
  logic [31:0] fuse_wdata;
  logic fuse_prog_strobe, fuse_sense_strobe;

  int total = 0;
  int bad = 0;
  logic [31:0] fm [128];

  always #(CLK_PERIOD/2) clk = ~clk;

  otp_seq_ctrl dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .fuse_addr(fuse_addr), .fuse_wdata(fuse_wdata),
    .fuse_prog_strobe(fuse_prog_strobe), .fuse_sense_strobe(fuse_sense_strobe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic int exp_width(input int cnt, input int relax);
    int t;
    t = cnt + 1 - 2 * (relax + 1);
    return (t < 1) ? 1 : t;
  endfunction

  // all tasks start and end at a falling edge
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 10000; i++) begin
      rd(A_CTRL, v);
      if (!v[8]) return;
    end
  endtask

  task automatic quiet(input int n, input string req);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      if (fuse_prog_strobe || fuse_sense_strobe) seen++;
      @(negedge clk);
    end
    check(req, seen, 0);
  endtask

  // called in the first cycle after the start write was taken
  task automatic measure(input bit prog, input int relax, input int w,
                         input logic [6:0] a, input logic [31:0] val);
    int pre = 0, sw = 0, post = 0;
    logic [31:0] v;
    logic strobe;
    strobe = prog ? fuse_prog_strobe : fuse_sense_strobe;
    while (!strobe && pre < 100) begin
      pre++; @(negedge clk);
      strobe = prog ? fuse_prog_strobe : fuse_sense_strobe;
    end
    check("R8 pre relax", pre, relax + 1);
    check("R5 fuse_addr", {25'b0, fuse_addr}, {25'b0, a});
    if (prog) check("R5 fuse_wdata", fuse_wdata, val);
    while (strobe && sw < 5000) begin
      sw++; @(negedge clk);
      strobe = prog ? fuse_prog_strobe : fuse_sense_strobe;
    end
    check("R8 strobe width", sw, w);
    for (int i = 0; i < 100; i++) begin
      rd(A_CTRL, v);
      if (!v[8]) break;
      post++;
    end
    check("R3 busy through post relax", post, relax + 1);
  endtask

  task automatic set_timing(input int tp, input int rl, input int tr);
    wr(A_TIM, {10'b0, tr[5:0], rl[3:0], tp[11:0]});
  endtask

  task automatic do_prog(input logic [6:0] a, input logic [31:0] val,
                         input int tp, input int rl, input int tr);
    logic [31:0] v;
    set_timing(tp, rl, tr);
    wr(A_CTRL, {KEY, 9'b0, a});
    wr(A_DATA, val);
    measure(1'b1, rl, exp_width(tp, rl), a, val);
    fm[a] = fm[a] | val;
    rd(A_CTRL, v);
    check("R9 key cleared", {16'b0, v[31:16]}, 32'h0);
  endtask

  task automatic do_sense(input logic [6:0] a, input int tp, input int rl, input int tr,
                          input string req);
    logic [31:0] v;
    set_timing(tp, rl, tr);
    wr(A_CTRL, {16'h0, 9'b0, a});
    wr(A_RDCTL, 32'h1);
    measure(1'b0, rl, exp_width(tr, rl), a, 32'h0);
    rd(A_RDDATA, v);
    check(req, v, fm[a]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 128; i++) fm[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 strobes idle", {30'b0, fuse_prog_strobe, fuse_sense_strobe}, 32'h0);
    rd(A_CTRL, v);  check("R1 ctrl reset", v, 32'h0);
    rd(A_TIM, v);   check("R1 timing reset", v, 32'h0);

    // R8 field layout
    wr(A_TIM, 32'hFFFF_FFFF);
    rd(A_TIM, v);   check("R8 timing fields", v, 32'h003F_FFFF);

    // R2 wrong key: error, no strobe, array untouched
    wr(A_CTRL, {16'h1234, 9'b0, 7'd5});
    wr(A_DATA, 32'h0000_00FF);
    quiet(12, "R2 no strobe on bad key");
    rd(A_CTRL, v);
    check("R2 error set", {31'b0, v[9]}, 32'h1);
    check("R2 not busy", {31'b0, v[8]}, 32'h0);

    // R4 sticky error and its clear register
    wr(A_CLR, 32'h0000_0100);
    rd(A_CTRL, v);  check("R4 clear without bit9", {31'b0, v[9]}, 32'h1);
    wr(A_CTRL, 32'h0000_0200);
    rd(A_CTRL, v);  check("R4 ctrl write keeps error", {31'b0, v[9]}, 32'h1);
    wr(A_CLR, 32'h0000_0200);
    rd(A_CTRL, v);  check("R4 cleared", {31'b0, v[9]}, 32'h0);
    do_sense(7'd5, 0, 1, 8, "R2 array untouched");

    // R5 R7 OR behaviour
    do_prog(7'd10, 32'h0000_0F0F, 20, 2, 10);
    do_prog(7'd10, 32'hF000_00F0, 20, 2, 10);
    do_sense(7'd10, 20, 2, 10, "R7 or of two burns");
    do_prog(7'd10, 32'h0000_0000, 5, 0, 3);
    do_sense(7'd10, 5, 0, 3, "R7 zero burn keeps word");

    // R8 minimum strobe width
    do_prog(7'd127, 32'h8000_0001, 0, 3, 0);
    do_sense(7'd127, 0, 3, 0, "R6 sense at top address");

    // R9 second burn without key rejected
    wr(A_DATA, 32'hFFFF_FFFF);
    quiet(8, "R9 no strobe without fresh key");
    rd(A_CTRL, v);  check("R9 error on keyless write", {31'b0, v[9]}, 32'h1);
    wr(A_CLR, 32'h0000_0200);
    do_sense(7'd127, 0, 3, 0, "R9 array unchanged");

    // R6 read control with bit0 clear
    wr(A_RDCTL, 32'hFFFF_FFFE);
    quiet(8, "R6 bit0 clear starts nothing");

    // R3 R10 R2 accesses during busy
    set_timing(40, 4, 10);
    wr(A_CTRL, {KEY, 9'b0, 7'd33});
    wr(A_DATA, 32'h0000_1111);
    wr(A_DATA, 32'h2222_0000);
    wr(A_RDCTL, 32'h1);
    wr(A_CTRL, {KEY, 9'b0, 7'd44});
    wait_idle();
    fm[33] = fm[33] | 32'h0000_1111;
    rd(A_CTRL, v);
    check("R10 R2 error after busy access", {31'b0, v[9]}, 32'h1);
    check("R3 ctrl write ignored while busy", {25'b0, v[6:0]}, 32'd33);
    wr(A_CLR, 32'h0000_0200);
    do_sense(7'd33, 40, 4, 10, "R10 running burn unaffected");
    do_sense(7'd44, 40, 4, 10, "R3 ignored address untouched");

    // random mix
    for (int it = 0; it < 40; it++) begin
      logic [6:0] a;
      int tp, rl, tr;
      a  = 7'($urandom % 12) + 7'd64;
      tp = int'($urandom % 64);
      rl = int'($urandom % 16);
      tr = int'($urandom % 64);
      if ($urandom % 2) do_prog(a, $urandom, tp, rl, tr);
      else              do_sense(a, tp, rl, tr, "R6 random sense");
      rd(A_CTRL, v);
      check("R2 no error on legal access", {31'b0, v[9]}, 32'h0);
    end
    for (int i = 64; i < 76; i++) do_sense(7'(i), 9, 1, 9, "R7 final contents");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule